// File: doc/BRIEF.md
# Multi-Cycle Multiply-Accumulate Unit

This block multiplies two 32-bit operands and either accumulates the product into a 64-bit accumulator or writes it to the accumulator's low half. The accumulator is visible as two 32-bit halves, `mach` (upper) and `macl` (lower). Operands arrive already fetched. Any address-register post-increment that goes with an accumulate is done by the surrounding pipeline.

An accepted operation is captured in one cycle, and the product is formed at that point. The write to the accumulator happens a fixed number of cycles later. `busy` is high while a result is pending, and further issues are refused during that time. A consumer that wants the accumulator raises `rd_req`. `stall` stays high until the pending result has been written. The accumulator can also be cleared or loaded one half at a time while the unit is idle.

Top module: `mac_unit`

## Requirements
- R1: After synchronous reset, `mach`, `macl`, `busy` and `stall` are all zero.
- R2: Opcode 1 (long accumulate) adds the signed 32x32 product of the operands to {`mach`,`macl`}, wrapping modulo 2^64.
- R3: Opcode 2 (word accumulate) adds the signed product of the low 16 bits of each operand to {`mach`,`macl`}, wrapping modulo 2^64.
- R4: Opcode 3 (long multiply) writes the low 32 bits of the 32x32 product to `macl` and leaves `mach` unchanged.
- R5: Opcode 4 (signed word multiply) writes the signed 32-bit product of the operands' low 16 bits to `macl` and leaves `mach` unchanged.
- R6: Opcode 5 (unsigned word multiply) writes the unsigned 32-bit product of the operands' low 16 bits to `macl` and leaves `mach` unchanged.
- R7: The accumulator keeps its previous value until the result is written. The write happens exactly `LONG_LAT` clock edges after the issue edge for opcodes 1, 2 and 3, and exactly `WORD_LAT` edges after it for opcodes 4 and 5.
- R8: `busy` rises in the cycle after an accepted issue and stays high for exactly the latency of that operation.
- R9: `stall` is high in every cycle in which `rd_req` is high and a result is pending. It is low once the result is visible.
- R10: An issue presented while `busy` is high is ignored. Opcodes 0, 6 and 7 are ignored at any time. Neither affects the accumulator or `busy`.
- R11: While idle, `clr` zeroes both halves, and `ld_hi` or `ld_lo` loads `ld_data` into `mach` or `macl`. A load wins over a clear for its own half. All three are ignored while `busy` is high.
- R12: For the word operations (opcodes 2, 4, 5), bits 31..16 of both operands have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Request to start an operation |
| issue_op | input | 3 | Operation code (1..5 valid) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| clr | input | 1 | Clear both accumulator halves when idle |
| ld_hi | input | 1 | Load `ld_data` into the upper half when idle |
| ld_lo | input | 1 | Load `ld_data` into the lower half when idle |
| ld_data | input | 32 | Data for accumulator loads |
| rd_req | input | 1 | Consumer wants to read the accumulator |
| busy | output | 1 | A result is pending; issues are refused |
| stall | output | 1 | Read must wait for the pending result |
| mach | output | 32 | Upper accumulator half |
| macl | output | 32 | Lower accumulator half |

## Verification
The hardest situation to create from the ports is a side request that arrives while a result is in flight. Two cases matter: a second issue, and a clear-plus-load. Each lands after the product has been captured but before writeback, when the accumulator must not move. The stimulus injects these in the first busy cycle of an operation. The bench then compares the single queued expected result at the falling edge of `busy`, so a leaked side effect or a second writeback shows up as a mismatch or an unexpected pop. Accumulate wrap-around is reached by loading all-ones into both halves before a 1x1 accumulate.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int OPND_W = 32;
    localparam int HALF_W = 16;
    localparam int ACC_W  = 2 * OPND_W;

    typedef enum logic [2:0] {
        MOP_NONE   = 3'd0,
        MOP_ACC32  = 3'd1,
        MOP_ACC16  = 3'd2,
        MOP_MUL32  = 3'd3,
        MOP_SMUL16 = 3'd4,
        MOP_UMUL16 = 3'd5,
        MOP_RSV6   = 3'd6,
        MOP_RSV7   = 3'd7
    } mac_op_e;

    typedef struct packed {
        mac_op_e            op;
        logic [ACC_W-1:0]   prod;
    } mac_job_t;

    function automatic logic op_legal(input mac_op_e op);
        return (op == MOP_ACC32) || (op == MOP_ACC16) || (op == MOP_MUL32) ||
               (op == MOP_SMUL16) || (op == MOP_UMUL16);
    endfunction

    function automatic logic op_accumulates(input mac_op_e op);
        return (op == MOP_ACC32) || (op == MOP_ACC16);
    endfunction

    function automatic logic op_long(input mac_op_e op);
        return (op == MOP_ACC32) || (op == MOP_ACC16) || (op == MOP_MUL32);
    endfunction

    // Product widened to the accumulator width; low bits are exact for every form.
    function automatic logic [ACC_W-1:0] mac_product(input mac_op_e op,
                                                     input logic [OPND_W-1:0] a,
                                                     input logic [OPND_W-1:0] b);
        logic [ACC_W-1:0] xa;
        logic [ACC_W-1:0] xb;
        case (op)
            MOP_ACC32, MOP_MUL32: begin
                xa = {{OPND_W{a[OPND_W-1]}}, a};
                xb = {{OPND_W{b[OPND_W-1]}}, b};
            end
            MOP_ACC16, MOP_SMUL16: begin
                xa = {{(ACC_W-HALF_W){a[HALF_W-1]}}, a[HALF_W-1:0]};
                xb = {{(ACC_W-HALF_W){b[HALF_W-1]}}, b[HALF_W-1:0]};
            end
            MOP_UMUL16: begin
                xa = {{(ACC_W-HALF_W){1'b0}}, a[HALF_W-1:0]};
                xb = {{(ACC_W-HALF_W){1'b0}}, b[HALF_W-1:0]};
            end
            default: begin
                xa = '0;
                xb = '0;
            end
        endcase
        return xa * xb;
    endfunction

endpackage

// File: rtl/mac_issue_ctrl.sv
module mac_issue_ctrl
    import mac_pkg::*;
#(
    parameter int LONG_LAT = 4,
    parameter int WORD_LAT = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    issue_valid,
    input  mac_op_e issue_op,
    output logic    accept,
    output logic    busy,
    output logic    wb_en
);
    localparam int CNT_W = $clog2(LONG_LAT + 1);
    localparam logic [CNT_W-1:0] LONG_CNT = CNT_W'(LONG_LAT);
    localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(WORD_LAT);

    logic [CNT_W-1:0] cnt;

    assign busy   = (cnt != '0);
    assign wb_en  = (cnt == CNT_W'(1));
    assign accept = issue_valid && !busy && op_legal(issue_op);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (accept) begin
            cnt <= op_long(issue_op) ? LONG_CNT : WORD_CNT;
        end else if (busy) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assert_busy_after_issue_R8: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    assert_issue_ignored_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && busy) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/mac_mult_stage.sv
module mac_mult_stage
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  mac_op_e           op,
    input  logic [OPND_W-1:0] a,
    input  logic [OPND_W-1:0] b,
    output mac_job_t          job
);
    always_ff @(posedge clk) begin
        if (rst) begin
            job <= '{op: MOP_NONE, prod: '0};
        end else if (capture) begin
            job.op   <= op;
            job.prod <= mac_product(op, a, b);
        end
    end
endmodule

// File: rtl/mac_acc_regs.sv
module mac_acc_regs
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              wb_en,
    input  mac_job_t          job,
    input  logic              clr,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic [OPND_W-1:0] ld_data,
    output logic [OPND_W-1:0] acc_hi,
    output logic [OPND_W-1:0] acc_lo
);
    logic [ACC_W-1:0] acc_sum;

    assign acc_sum = {acc_hi, acc_lo} + job.prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else if (wb_en) begin
            if (op_accumulates(job.op)) begin
                acc_hi <= acc_sum[ACC_W-1:OPND_W];
                acc_lo <= acc_sum[OPND_W-1:0];
            end else begin
                acc_lo <= job.prod[OPND_W-1:0];
            end
        end else if (!busy) begin
            if (ld_hi)    acc_hi <= ld_data;
            else if (clr) acc_hi <= '0;
            if (ld_lo)    acc_lo <= ld_data;
            else if (clr) acc_lo <= '0;
        end
    end

    assert_mul_keeps_hi_R4: assert property (@(posedge clk) disable iff (rst)
        (wb_en && !op_accumulates(job.op)) |=> $stable(acc_hi));

    assert_hold_while_pending_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && !wb_en) |=> ($stable(acc_hi) && $stable(acc_lo)));

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int LONG_LAT = 4,
    parameter int WORD_LAT = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        issue_valid,
    input  logic [2:0]  issue_op,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic        clr,
    input  logic        ld_hi,
    input  logic        ld_lo,
    input  logic [31:0] ld_data,
    input  logic        rd_req,
    output logic        busy,
    output logic        stall,
    output logic [31:0] mach,
    output logic [31:0] macl
);
    mac_op_e  op_in;
    logic     accept;
    logic     wb_en;
    mac_job_t job;

    assign op_in = mac_op_e'(issue_op);
    assign stall = rd_req && busy;

    mac_issue_ctrl #(.LONG_LAT(LONG_LAT), .WORD_LAT(WORD_LAT)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .issue_valid (issue_valid),
        .issue_op    (op_in),
        .accept      (accept),
        .busy        (busy),
        .wb_en       (wb_en)
    );

    mac_mult_stage u_mult (
        .clk     (clk),
        .rst     (rst),
        .capture (accept),
        .op      (op_in),
        .a       (opnd_a),
        .b       (opnd_b),
        .job     (job)
    );

    mac_acc_regs u_acc (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy),
        .wb_en   (wb_en),
        .job     (job),
        .clr     (clr),
        .ld_hi   (ld_hi),
        .ld_lo   (ld_lo),
        .ld_data (ld_data),
        .acc_hi  (mach),
        .acc_lo  (macl)
    );

    assert_release_on_write_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(wb_en));

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && mach == '0 && macl == '0));

endmodule

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LONG_LAT   = 4;
    localparam int WORD_LAT   = 2;

    logic        clk = 0;
    logic        rst = 1;
    logic        issue_valid = 0;
    logic [2:0]  issue_op = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        clr = 0;
    logic        ld_hi = 0;
    logic        ld_lo = 0;
    logic [31:0] ld_data = '0;
    logic        rd_req = 0;
    logic        busy, stall;
    logic [31:0] mach, macl;

    mac_unit #(.LONG_LAT(LONG_LAT), .WORD_LAT(WORD_LAT)) u0 (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .clr(clr), .ld_hi(ld_hi), .ld_lo(ld_lo),
        .ld_data(ld_data), .rd_req(rd_req), .busy(busy), .stall(stall),
        .mach(mach), .macl(macl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [31:0] hi;
        logic [31:0] lo;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          errors = 0;
    logic [31:0] m_hi = '0;
    logic [31:0] m_lo = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // Monitor: pops one expected item each time a pending result completes.
    initial begin
        logic pb;
        exp_t e;
        pb = 0;
        forever begin
            @(negedge clk);
            if (pb && !busy) begin
                if (sb_q.size() == 0) begin
                    check(0, "R10", "unexpected writeback", {mach, macl}, {m_hi, m_lo});
                end else begin
                    e = sb_q.pop_front();
                    check({mach, macl} == {e.hi, e.lo}, e.tag, "result",
                          {mach, macl}, {e.hi, e.lo});
                end
            end
            pb = busy;
        end
    end

    // Driver: poke 1 = extra issue while busy, poke 2 = clear+load while busy.
    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                          input bit rd, input int poke, input string tag);
        logic [31:0] oh, ol;
        logic [63:0] sum;
        int lat, nb;
        oh = m_hi;
        ol = m_lo;
        case (op)
            3'd1: begin
                sum = {m_hi, m_lo} + 64'(longint'($signed(a)) * longint'($signed(b)));
                {m_hi, m_lo} = sum;
            end
            3'd2: begin
                sum = {m_hi, m_lo} + 64'(longint'($signed(a[15:0])) * longint'($signed(b[15:0])));
                {m_hi, m_lo} = sum;
            end
            3'd3: m_lo = a * b;
            3'd4: m_lo = 32'(int'($signed(a[15:0])) * int'($signed(b[15:0])));
            3'd5: m_lo = {16'h0, a[15:0]} * {16'h0, b[15:0]};
            default: ;
        endcase
        lat = (op inside {3'd1, 3'd2, 3'd3}) ? LONG_LAT : WORD_LAT;
        sb_q.push_back('{m_hi, m_lo, tag});
        @(negedge clk);
        issue_valid = 1; issue_op = op; opnd_a = a; opnd_b = b;
        @(negedge clk);
        issue_valid = 0; rd_req = rd; nb = 0;
        while (busy) begin
            #1;
            if (nb == 0)
                check({mach, macl} == {oh, ol}, "R7", "held before writeback", {mach, macl}, {oh, ol});
            if (rd)
                check(stall == 1'b1, "R9", "stall while pending", 64'(stall), 64'd1);
            if (nb == 0 && poke == 1) begin
                issue_valid = 1; issue_op = 3'd1; opnd_a = 32'd1000; opnd_b = 32'd77;
            end
            if (nb == 0 && poke == 2) begin
                clr = 1; ld_hi = 1; ld_data = 32'hDEAD_BEEF;
            end
            @(negedge clk);
            issue_valid = 0; clr = 0; ld_hi = 0;
            nb++;
        end
        #1;
        if (rd)
            check(stall == 1'b0, "R9", "stall released", 64'(stall), 64'd0);
        rd_req = 0;
        check(nb == lat, "R8", "busy cycles", 64'(nb), 64'(lat));
        check(busy == 1'b0, "R10", "no second operation", 64'(busy), 64'd0);
    endtask

    task automatic load(input bit c, input bit h, input bit l, input logic [31:0] d);
        @(negedge clk);
        clr = c; ld_hi = h; ld_lo = l; ld_data = d;
        if (c) begin m_hi = '0; m_lo = '0; end
        if (h) m_hi = d;
        if (l) m_lo = d;
        @(negedge clk);
        clr = 0; ld_hi = 0; ld_lo = 0;
        #1;
        check({mach, macl} == {m_hi, m_lo}, "R11", "clear/load", {mach, macl}, {m_hi, m_lo});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check(mach == '0, "R1", "mach after reset", 64'(mach), 64'd0);
        check(macl == '0, "R1", "macl after reset", 64'(macl), 64'd0);
        check(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);
        check(stall == 1'b0, "R1", "stall after reset", 64'(stall), 64'd0);

        load(0, 1, 0, 32'h0000_0001);
        load(0, 0, 1, 32'hFFFF_FFF0);
        run_op(3'd1, 32'hFFFF_FFFD, 32'd7, 1, 0, "R2");
        run_op(3'd1, 32'h8000_0000, 32'h8000_0000, 0, 0, "R2");
        run_op(3'd2, 32'hABCD_8000, 32'h1234_7FFF, 1, 0, "R3 R12");
        run_op(3'd2, 32'h0000_FFFF, 32'h0000_0002, 0, 1, "R3 R10");
        run_op(3'd3, 32'h1234_5678, 32'h9ABC_DEF0, 1, 0, "R4");
        run_op(3'd4, 32'hFFFF_8000, 32'h0001_7FFF, 1, 0, "R5 R12");
        run_op(3'd5, 32'h5555_FFFF, 32'hAAAA_FFFF, 1, 0, "R6 R12");
        run_op(3'd3, 32'hFFFF_FFFF, 32'h0000_0003, 0, 2, "R4 R11");

        // R10: reserved opcode while idle
        @(negedge clk);
        issue_valid = 1; issue_op = 3'd6; opnd_a = 32'd5; opnd_b = 32'd5;
        @(negedge clk);
        issue_valid = 0;
        #1;
        check(busy == 1'b0, "R10", "reserved opcode busy", 64'(busy), 64'd0);
        @(negedge clk);
        #1;
        check({mach, macl} == {m_hi, m_lo}, "R10", "reserved opcode no effect",
              {mach, macl}, {m_hi, m_lo});

        load(1, 0, 0, 32'h1111_1111);
        load(1, 1, 0, 32'h2222_2222);
        load(0, 1, 1, 32'hFFFF_FFFF);
        run_op(3'd1, 32'd1, 32'd1, 1, 0, "R2 wrap");

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R7", "all results written", 64'(sb_q.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule